// File: doc/BRIEF.md
# Byte-Addressed I2C Register Slave with Broadcast Filter

This block is the bus-facing front end of a measurement core. An external I2C master reaches a 256-entry byte register space through it. Every transfer names its target register explicitly: a write carries the device address, one pointer byte and one data byte. A read first writes the pointer, then sends a repeated START and the device address with the read bit, and clocks out one byte. The pointer never advances by itself, so any byte after the first data byte of a write is refused.

Four locations are handled inside the block:

| Pointer | Register | Access | Contents |
|---|---|---|---|
| 0x00 | status | read-only | bit 0 = ready, bit 1 = error register non-zero |
| 0x01 | command | write-only | command code; reads as 0x00 |
| 0x02 | error | read-only | 0x00 = no error, 0xFE = parameter error |
| 0x30 | address staging | read/write | a new 7-bit address, waiting to take effect |

Every other pointer is passed to the rest of the core through a simple one-cycle write strobe and a combinational read-data input. Commands become one-cycle strobes toward the core. A write to the staging register does not move the block off its current address. The staged value must first be saved and then committed by a reset command.

The block also answers the broadcast address 0x00, but only for writes, and only for the latch and reset commands. Anything else sent that way is dropped, and the drop is reported in the error register. SCL and SDA are sampled on the system clock through two flip-flops each. The block drives SDA only by pulling it low through `sda_oe`.

Top module: `i2c_regslave`

## Requirements
- R1: After reset the block answers address 0x50. Status reads 0x01, the error register reads 0x00, and the staging register (pointer 0x30) reads 0x50.
- R2: An address byte is ACKed only when its 7-bit address equals the active address, or when it is 0x00 with the write bit (bit 0 = 0). Every other address is NACKed, and SDA stays released for the rest of that transfer.
- R3: A write transaction carries exactly one data byte after the pointer. Further bytes in the same transaction are NACKed, and they cause no register write and no strobe.
- R4: A write to any pointer other than 0x00, 0x01, 0x02 and 0x30 produces one `core_wr` pulse with `core_addr` equal to the pointer and `core_wdata` equal to the data. A read from such a pointer returns `core_rdata` for that pointer.
- R5: Writing command code 0x00 to pointer 0x01 has no effect. Code 0x27 pulses `latch_stb`, code 0x26 pulses `save_stb`, and code 0x01 pulses `reset_stb`. Each strobe lasts exactly one clock, and at most one strobe is high at a time.
- R6: Any other command code sets the error register to 0xFE and raises no strobe.
- R7: The error register holds either 0x00 or a code with bit 7 set. Once set, it keeps its value until a reset command clears it to 0x00. Later successful accesses do not clear it.
- R8: Status bit 1 reads 1 exactly when the error register is non-zero. Status bit 0 reads 1 once the block is ready. Bits 7..2 read 0.
- R9: A write of 0x08..0x77 to pointer 0x30 loads the staging register. Any other value leaves the staging register unchanged and sets the error register to 0xFE.
- R10: The active address changes only on a reset command. The reset command loads the value captured by the most recent save command, so a staged value that has not been saved has no effect.
- R11: On the broadcast address, only a write of 0x27 or 0x01 to pointer 0x01 is executed. Any other broadcast write is ignored and sets the error register to 0xFE. A broadcast read is NACKed.
- R12: A write to a read-only register (pointer 0x00 or 0x02) changes nothing except the error register, which becomes 0xFE.
- R13: A START or STOP is recognised on an SDA edge while SCL is high. The block changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| latch_stb | output | 1 | One-cycle period-latch command strobe |
| reset_stb | output | 1 | One-cycle reset command strobe |
| save_stb | output | 1 | One-cycle save command strobe |
| core_wr | output | 1 | One-cycle write strobe to the core register space |
| core_addr | output | 8 | Current register pointer |
| core_wdata | output | 8 | Data byte for a core write |
| core_rdata | input | 8 | Core register contents at `core_addr` |

## Verification
The hardest state to reach is a changed active address. The bus address moves only after three separate transactions: a stage write, a save command and a reset command. A reset issued before the save must leave the address where it was.

The stimulus drives that sequence from the ports. It first sends a reset without a save and confirms the new address is still NACKed. It then sends the save and the reset and confirms that only the new address is ACKed. Finally it moves back to 0x50 by the same route, talking to the block at its temporary address.

A second hard spot is broadcast filtering. Broadcast writes of a saved command and of a core register must be proven harmless. For that, the stimulus watches every clock for stray strobes and then reads the error register back.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEF_ADDR = 7'h50,
  parameter logic [6:0] ADDR_LO  = 7'h08,
  parameter logic [6:0] ADDR_HI  = 7'h77,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          latch_stb,
  output logic          reset_stb,
  output logic          save_stb,
  output logic          core_wr,
  output logic [DW-1:0] core_addr,
  output logic [DW-1:0] core_wdata,
  input  logic [DW-1:0] core_rdata
);
  localparam logic [DW-1:0] P_STAT  = 8'h00;
  localparam logic [DW-1:0] P_CMD   = 8'h01;
  localparam logic [DW-1:0] P_ERR   = 8'h02;
  localparam logic [DW-1:0] P_ADDR  = 8'h30;
  localparam logic [DW-1:0] E_PARAM = 8'hFE;
  localparam logic [3:0]    BITS    = 4'(DW);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WDAT, S_RDAT, S_SKIP} st_t;

  logic [2:0]    scl_s, sda_s;
  st_t           st, nxt;
  logic [3:0]    cnt;
  logic [DW-1:0] sh, tx, ptr, err, rd_val;
  logic [6:0]    staged, saved, active;
  logic          gc, ready;

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire bus_start = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire bus_stop  = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire rx_state  = (st == S_ADDR) || (st == S_PTR) || (st == S_WDAT);
  wire own_hit   = sh[7:1] == active;
  wire gc_hit    = (sh[7:1] == 7'h00) && !sh[0];
  wire in_range  = !sh[7] && (sh[6:0] >= ADDR_LO) && (sh[6:0] <= ADDR_HI);
  wire gc_ok     = (ptr == P_CMD) && ((sh == 8'h27) || (sh == 8'h01));

  assign core_addr  = ptr;
  assign core_wdata = sh;

  always_comb begin
    case (ptr)
      P_STAT:  rd_val = {6'b0, |err, ready};
      P_CMD:   rd_val = '0;
      P_ERR:   rd_val = err;
      P_ADDR:  rd_val = {1'b0, staged};
      default: rd_val = core_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      gc <= 1'b0; sda_oe <= 1'b0; err <= '0; ready <= 1'b0;
      staged <= DEF_ADDR; saved <= DEF_ADDR; active <= DEF_ADDR;
      latch_stb <= 1'b0; reset_stb <= 1'b0; save_stb <= 1'b0; core_wr <= 1'b0;
    end else begin
      latch_stb <= 1'b0; reset_stb <= 1'b0; save_stb <= 1'b0; core_wr <= 1'b0;
      ready <= 1'b1;
      if (bus_start) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        if (scl_rise && rx_state && cnt < BITS) begin
          sh  <= {sh[DW-2:0], sda_s[1]};
          cnt <= cnt + 4'd1;
        end
        if (scl_fall) begin
          if (st == S_RDAT) begin
            if (cnt < BITS) begin
              sda_oe <= ~tx[DW-1];
              tx     <= {tx[DW-2:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_SKIP;
            end
          end else if (rx_state && cnt == BITS) begin
            cnt <= BITS + 4'd1;
            case (st)
              S_ADDR: begin
                sda_oe <= own_hit | gc_hit;
                gc     <= gc_hit;
                tx     <= rd_val;
                nxt    <= !(own_hit | gc_hit) ? S_SKIP : (sh[0] ? S_RDAT : S_PTR);
              end
              S_PTR: begin
                sda_oe <= 1'b1;
                ptr    <= sh;
                nxt    <= S_WDAT;
              end
              default: begin
                sda_oe <= 1'b1;
                nxt    <= S_SKIP;
                if (gc && !gc_ok) err <= E_PARAM;
                else case (ptr)
                  P_CMD: case (sh)
                    8'h00: ;
                    8'h01: begin
                      reset_stb <= 1'b1; err <= '0; active <= saved; ready <= 1'b0;
                    end
                    8'h26: begin save_stb <= 1'b1; saved <= staged; end
                    8'h27: latch_stb <= 1'b1;
                    default: err <= E_PARAM;
                  endcase
                  P_ADDR: if (in_range) staged <= sh[6:0]; else err <= E_PARAM;
                  P_STAT, P_ERR: err <= E_PARAM;
                  default: core_wr <= 1'b1;
                endcase
              end
            endcase
          end else if (rx_state && cnt == BITS + 4'd1) begin
            st <= nxt;
            if (nxt == S_RDAT) begin
              sda_oe <= ~tx[DW-1];
              tx     <= {tx[DW-2:0], 1'b0};
              cnt    <= 4'd1;
            end else begin
              sda_oe <= 1'b0;
              cnt    <= '0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       latch_stb,
  input logic       reset_stb,
  input logic       save_stb,
  input logic [7:0] err_q,
  input logic [6:0] staged_q,
  input logic [6:0] active_q
);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({latch_stb, reset_stb, save_stb}));
  assert_latch_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> !latch_stb);
  assert_save_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    save_stb |=> !save_stb);
  assert_err_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 8'h00) |-> err_q[7]);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 8'h00) |=> (err_q == $past(err_q)) || reset_stb);
  assert_staged_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (staged_q >= 7'h08) && (staged_q <= 7'h77));
  assert_active_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_q) |-> reset_stb);
  assert_sda_low_scl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .latch_stb(latch_stb), .reset_stb(reset_stb), .save_stb(save_stb),
  .err_q(err), .staged_q(staged), .active_q(active)
);

// File: tb/test_i2c_regslave.sv
module test_i2c_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8 * CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, latch_stb, reset_stb, save_stb, core_wr;
  logic [7:0] core_addr, core_wdata, core_rdata;
  wire sda = sda_m & ~sda_oe;
  int vectors = 0, fails = 0;
  bit done = 0;

  logic [6:0] m_active = 7'h50, m_staged = 7'h50, m_saved = 7'h50;
  logic [7:0] m_err = 8'h00;
  logic [23:0] expq[$];

  assign core_rdata = core_addr ^ 8'hA5;

  i2c_regslave i_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .latch_stb(latch_stb), .reset_stb(reset_stb), .save_stb(save_stb),
    .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // R5 R4: every clock, compare strobes with the model's queue
  always @(negedge clk) begin
    if (rst_n && (latch_stb || reset_stb || save_stb || core_wr)) begin
      logic [23:0] got, exp;
      got = latch_stb ? 24'h010000 : reset_stb ? 24'h020000 : save_stb ? 24'h030000
          : {8'h04, core_addr, core_wdata};
      if ((latch_stb + reset_stb + save_stb + core_wr) > 1) got = 24'hFFFFFF;
      exp = (expq.size() > 0) ? expq.pop_front() : 24'h000000;
      chk("R5 strobe", got, exp);
    end
  end

  task automatic model_write(input bit gcast, input logic [7:0] p, input logic [7:0] v);
    if (gcast && !(p == 8'h01 && (v == 8'h27 || v == 8'h01))) m_err = 8'hFE;
    else if (p == 8'h01) begin
      if (v == 8'h01) begin expq.push_back(24'h020000); m_err = 8'h00; m_active = m_saved; end
      else if (v == 8'h26) begin expq.push_back(24'h030000); m_saved = m_staged; end
      else if (v == 8'h27) expq.push_back(24'h010000);
      else if (v != 8'h00) m_err = 8'hFE;
    end else if (p == 8'h30) begin
      if (v >= 8'h08 && v <= 8'h77) m_staged = v[6:0]; else m_err = 8'hFE;
    end else if (p == 8'h00 || p == 8'h02) m_err = 8'hFE;
    else expq.push_back({8'h04, p, v});
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] p);
    case (p)
      8'h00: return {6'b0, m_err != 0, 1'b1};
      8'h01: return 8'h00;
      8'h02: return m_err;
      8'h30: return {1'b0, m_staged};
      default: return p ^ 8'hA5;
    endcase
  endfunction

  task automatic bus_start();
    sda_m = 1; #Q; scl = 1; #Q; sda_m = 0; #Q; scl = 0; #Q;
  endtask
  task automatic bus_stop();
    sda_m = 0; #Q; scl = 1; #Q; sda_m = 1; #Q;
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl = 1; #(2*Q); scl = 0; #Q;
    end
    sda_m = 1; #Q; scl = 1; #Q; ack = !sda; #Q; scl = 0; #Q;
  endtask
  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1; #Q; b[i] = sda; #Q; scl = 0; #Q;
    end
    #Q; scl = 1; #(2*Q); scl = 0; #Q;
  endtask

  task automatic wr(input string req, input logic [6:0] a, input logic [7:0] p,
                    input logic [7:0] v, input bit extra);
    bit hit, ack;
    hit = (a == m_active) || (a == 7'h00);
    if (hit) model_write(a == 7'h00, p, v);
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk({req, " R2 addr ack"}, ack, hit);
    if (ack) begin
      send_byte(p, ack);  chk({req, " ptr ack"}, ack, 1);
      send_byte(v, ack);  chk({req, " data ack"}, ack, 1);
      if (extra) begin send_byte(~v, ack); chk("R3 extra byte nack", ack, 0); end
    end
    bus_stop();
    #(4*Q);
    chk({req, " R5 pending strobes"}, expq.size(), 0);
  endtask

  task automatic rd(input string req, input logic [6:0] a, input logic [7:0] p);
    bit hit, ack;
    logic [7:0] d;
    hit = (a == m_active);
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk({req, " R2 addr ack"}, ack, hit);
    if (ack) begin
      send_byte(p, ack);
      bus_start();
      send_byte({a, 1'b1}, ack);
      recv_byte(d);
      chk({req, " read data"}, d, model_read(p));
    end
    bus_stop();
    #(2*Q);
  endtask

  task automatic gc_read();
    bit ack;
    bus_start(); send_byte(8'h01, ack); bus_stop();
    chk("R11 broadcast read nack", ack, 0);
    #(2*Q);
  endtask

  initial begin
    #(150000*CLK_PERIOD);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(5*CLK_PERIOD); rst_n = 1; #(5*CLK_PERIOD);
    chk("R1 sda released", sda_oe, 0);
    rd("R1 status", 7'h50, 8'h00);
    rd("R1 error", 7'h50, 8'h02);
    rd("R1 staged", 7'h50, 8'h30);
    wr("R4 core write", 7'h50, 8'h40, 8'h31, 0);
    rd("R4 core read", 7'h50, 8'h40);
    wr("R4 core write high", 7'h50, 8'hFF, 8'h00, 0);
    wr("R2 foreign addr", 7'h51, 8'h40, 8'h11, 0);
    rd("R2 foreign read", 7'h2A, 8'h00);
    wr("R3 no increment", 7'h50, 8'h41, 8'h12, 1);
    rd("R3 next reg unchanged", 7'h50, 8'h42);
    wr("R5 latch", 7'h50, 8'h01, 8'h27, 0);
    wr("R5 nop", 7'h50, 8'h01, 8'h00, 0);
    rd("R5 nop no error", 7'h50, 8'h02);
    rd("R5 command reads zero", 7'h50, 8'h01);
    wr("R9 low bound", 7'h50, 8'h30, 8'h08, 0);
    rd("R9 low bound read", 7'h50, 8'h30);
    wr("R9 high bound", 7'h50, 8'h30, 8'h77, 0);
    rd("R9 high bound read", 7'h50, 8'h30);
    wr("R10 stage", 7'h50, 8'h30, 8'h22, 0);
    wr("R10 reset unsaved", 7'h50, 8'h01, 8'h01, 0);
    rd("R10 new addr idle", 7'h22, 8'h00);
    rd("R10 old addr alive", 7'h50, 8'h30);
    wr("R10 save", 7'h50, 8'h01, 8'h26, 0);
    rd("R10 save alone", 7'h22, 8'h00);
    wr("R10 commit", 7'h50, 8'h01, 8'h01, 0);
    rd("R10 new addr live", 7'h22, 8'h00);
    rd("R10 old addr gone", 7'h50, 8'h00);
    wr("R10 restage", 7'h22, 8'h30, 8'h50, 0);
    wr("R10 resave", 7'h22, 8'h01, 8'h26, 0);
    wr("R10 recommit", 7'h22, 8'h01, 8'h01, 0);
    rd("R10 back home", 7'h50, 8'h30);
    wr("R9 out of range", 7'h50, 8'h30, 8'h78, 0);
    rd("R9 staged kept", 7'h50, 8'h30);
    rd("R7 error code", 7'h50, 8'h02);
    rd("R8 status error bit", 7'h50, 8'h00);
    wr("R7 good access", 7'h50, 8'h44, 8'h5A, 0);
    rd("R7 error sticky", 7'h50, 8'h02);
    wr("R7 clear by reset", 7'h50, 8'h01, 8'h01, 0);
    rd("R7 cleared", 7'h50, 8'h02);
    rd("R8 status clean", 7'h50, 8'h00);
    wr("R6 unknown cmd", 7'h50, 8'h01, 8'h55, 0);
    rd("R6 error set", 7'h50, 8'h02);
    wr("R6 clear", 7'h50, 8'h01, 8'h01, 0);
    wr("R12 write status", 7'h50, 8'h00, 8'h05, 0);
    rd("R12 status after", 7'h50, 8'h00);
    wr("R12 clear", 7'h50, 8'h01, 8'h01, 0);
    wr("R12 write error", 7'h50, 8'h02, 8'h00, 0);
    rd("R12 error after", 7'h50, 8'h02);
    wr("R12 clear2", 7'h50, 8'h01, 8'h01, 0);
    wr("R11 bcast latch", 7'h00, 8'h01, 8'h27, 0);
    rd("R11 latch no error", 7'h50, 8'h02);
    wr("R11 bcast save", 7'h00, 8'h01, 8'h26, 0);
    rd("R11 save rejected", 7'h50, 8'h02);
    wr("R11 bcast core", 7'h00, 8'h40, 8'h11, 0);
    rd("R11 core untouched", 7'h50, 8'h02);
    gc_read();
    wr("R11 bcast reset", 7'h00, 8'h01, 8'h01, 0);
    rd("R11 reset cleared", 7'h50, 8'h02);
    rd("R13 still responsive", 7'h50, 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule